// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block holds the interrupt state of a small processor system: a pending register whose bits are raised by peripheral event pulses, and an enable register chosen by software. Both sit at fixed offsets of an I/O page and take either a 16-bit or a 32-bit write. A single request line goes to the CPU. It stays high while any pending bit is also enabled.

Software acknowledges events by writing the pending register. The new pending value is the old value ANDed with the enable register and with the written word. A zero in the written word therefore clears that bit. Any bit that is disabled is also dropped by every such write. Two configuration inputs can force the serial bit (7) and the sound bit (9) to one just before that AND. A write to the enable register stores the value. If the stored enables meet any pending bit, the write raises a one-cycle "check needed" pulse.

Top module: `irq_ctrl_top`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears pending and enable to zero. After reset, irq and check_req are both low.
- R2: A one in src_pulse[i] sets pending bit i at the next clock edge. The bit then holds until a pending-register write clears it.
- R3: A 32-bit write (wr_word=1) to offset 0x070 sets pending to pending AND enable AND wr_data. A zero in the data acknowledges that bit.
- R4: Every pending-register write clears each pending bit in the written half whose enable bit is zero, even when the data bit is one.
- R5: During a pending-register write, force_serial sets bit 7 and force_sound sets bit 9 to one before the AND. The forced bit survives only where both enable and data are one.
- R6: A write to offset 0x074 stores wr_data in enable. check_req is high for exactly the one cycle after that write when (pending before the write) AND (new enable) is nonzero. Otherwise check_req stays low.
- R7: irq is high exactly when pending AND enable is nonzero. It follows the registers in the same cycle.
- R8: A source pulse in the same cycle as an acknowledging write sets its bit. The new event is not lost.
- R9: A 16-bit write (wr_word=0) uses wr_data[15:0] and changes only bits 15:0 of the addressed register. Bits 31:16 keep their values; in the pending register they can still be raised by source pulses.
- R10: A write to any other offset, including 0x072 and 0x078, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Byte offset within the I/O page |
| wr_word | input | 1 | 1 = 32-bit write, 0 = 16-bit write (low half) |
| wr_data | input | 32 | Write data |
| src_pulse | input | 32 | Per-bit event pulses from peripherals (DMA uses bit 3) |
| force_serial | input | 1 | Force bit 7 pending before an acknowledge |
| force_sound | input | 1 | Force bit 9 pending before an acknowledge |
| pending_o | output | 32 | Current pending register |
| enable_o | output | 32 | Current enable register |
| irq | output | 1 | Interrupt request to the CPU |
| check_req | output | 1 | One-cycle pulse: an enable write met a pending bit |

## Verification
The bench builds the block with its default parameters: a 32-bit data path split into two 16-bit lanes, with the serial and sound bits at 7 and 9. With two lanes it can show that a half write keeps the upper lane intact, in both the pending and the enable register. The fixed bit positions let it check that forcing interacts correctly with both the enable mask and the written data. A same-cycle source pulse and acknowledge, and a write just beside the register offsets, are also reached directly.

// File: rtl/irq_ctrl_pkg.sv
// Shared types for the interrupt pending/enable controller.
package irq_ctrl_pkg;
    // Decoded target of a bus write
    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_PENDING = 2'd1,
        TGT_ENABLE  = 2'd2
    } wr_target_e;
endpackage

// File: rtl/irq_lane_sel.sv
// Lane enable generator: turns the access size into one enable per
// half-word lane. Assumes a narrow access always targets lane 0.
module irq_lane_sel #(
    parameter int LANES = 2
) (
    input  logic             wide,
    output logic [LANES-1:0] lane_en
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            // lowest lane is written by every access size
            assign lane_en[l] = 1'b1;
        end else begin : g_high
            // upper lanes only by a full-word access
            assign lane_en[l] = wide;
        end
    end
endmodule

// File: rtl/irq_pending_reg.sv
// Pending register: collects source pulses and applies acknowledge writes
// lane by lane (pending & enable & data, after forcing two bits).
// Assumes source pulses are one clock wide and synchronous to clk.
module irq_pending_reg #(
    parameter int DATA_W     = 32,
    parameter int LANE_W     = 16,
    parameter int SERIAL_BIT = 7,
    parameter int SOUND_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W/LANE_W-1:0] lane_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] enable_q,
    input  logic [DATA_W-1:0] src,
    input  logic              force_serial,
    input  logic              force_sound,
    output logic [DATA_W-1:0] pending_q
);
    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] forced;
    logic [DATA_W-1:0] pend_nxt;

    // pending value with the two optional bits forced on
    always_comb begin
        forced = pending_q;
        if (force_serial) forced[SERIAL_BIT] = 1'b1;
        if (force_sound)  forced[SOUND_BIT]  = 1'b1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;
        // per-lane next value: acknowledge on write, else hold; sources always OR in
        always_comb begin
            if (wr && lane_en[l])
                pend_nxt[LO +: LANE_W] = (forced[LO +: LANE_W] & enable_q[LO +: LANE_W]
                                          & wdata[LO +: LANE_W]) | src[LO +: LANE_W];
            else
                pend_nxt[LO +: LANE_W] = pending_q[LO +: LANE_W] | src[LO +: LANE_W];
        end
    end

    // register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= pend_nxt;
    end

    // R3
    ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (&lane_en) && wdata == '0 && src == '0) |=> pending_q == '0);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && src == '0) |=> $stable(pending_q));
    // R8
    src_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0) |=> ((pending_q & $past(src)) == $past(src)));
    // R9
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !lane_en[LANES-1] && src[DATA_W-1:LANE_W] == '0)
        |=> $stable(pending_q[DATA_W-1:LANE_W]));
endmodule

// File: rtl/irq_enable_reg.sv
// Enable register: stores written lanes and raises a one-cycle check
// pulse when the new enables meet a pending bit. Assumes pending_q is the
// value before any update in the same cycle.
module irq_enable_reg #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W/LANE_W-1:0] lane_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pending_q,
    output logic [DATA_W-1:0] enable_q,
    output logic              check_req
);
    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] en_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;
        // per-lane next enable: replaced on write, else held
        always_comb begin
            if (wr && lane_en[l]) en_nxt[LO +: LANE_W] = wdata[LO +: LANE_W];
            else                  en_nxt[LO +: LANE_W] = enable_q[LO +: LANE_W];
        end
    end

    // enable storage and check pulse with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q  <= '0;
            check_req <= 1'b0;
        end else begin
            enable_q  <= en_nxt;
            check_req <= wr && ((pending_q & en_nxt) != '0);
        end
    end

    // R6
    check_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_req |-> $past(wr));
    // R6
    check_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> !check_req);
    // R9
    en_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && lane_en[LANES-1])) |=> $stable(enable_q[DATA_W-1:LANE_W]));
endmodule

// File: rtl/irq_ctrl_top.sv
// Interrupt pending/enable controller top: decodes bus writes onto the two
// registers and drives the CPU request. Assumes writes are single-cycle
// strobes and that a 16-bit write always carries its data in bits 15:0.
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          LANE_W      = 16,
    parameter int          ADDR_W      = 12,
    parameter int          SERIAL_BIT  = 7,
    parameter int          SOUND_BIT   = 9,
    parameter logic [11:0] PENDING_OFS = 12'h070,
    parameter logic [11:0] ENABLE_OFS  = 12'h074
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] src_pulse,
    input  logic              force_serial,
    input  logic              force_sound,
    output logic [DATA_W-1:0] pending_o,
    output logic [DATA_W-1:0] enable_o,
    output logic              irq,
    output logic              check_req
);
    localparam int LANES = DATA_W / LANE_W;

    wr_target_e       tgt;
    logic [LANES-1:0] lane_en;

    // address decode of the write strobe
    always_comb begin
        tgt = TGT_NONE;
        if (wr_en && wr_addr == ADDR_W'(PENDING_OFS)) tgt = TGT_PENDING;
        else if (wr_en && wr_addr == ADDR_W'(ENABLE_OFS)) tgt = TGT_ENABLE;
    end

    irq_lane_sel #(.LANES(LANES)) u_lanes (
        .wide    (wr_word),
        .lane_en (lane_en)
    );

    irq_pending_reg #(
        .DATA_W(DATA_W), .LANE_W(LANE_W),
        .SERIAL_BIT(SERIAL_BIT), .SOUND_BIT(SOUND_BIT)
    ) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (tgt == TGT_PENDING),
        .lane_en      (lane_en),
        .wdata        (wr_data),
        .enable_q     (enable_o),
        .src          (src_pulse),
        .force_serial (force_serial),
        .force_sound  (force_sound),
        .pending_q    (pending_o)
    );

    irq_enable_reg #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tgt == TGT_ENABLE),
        .lane_en   (lane_en),
        .wdata     (wr_data),
        .pending_q (pending_o),
        .enable_q  (enable_o),
        .check_req (check_req)
    );

    // CPU request: any pending bit that is enabled
    always_comb irq = (pending_o & enable_o) != '0;

    // R7
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o == '0) |-> !irq);
    // R10
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(PENDING_OFS) && wr_addr != ADDR_W'(ENABLE_OFS)
         && src_pulse == '0) |=> ($stable(pending_o) && $stable(enable_o)));
    // R1
    reset_chk: assert property (@(posedge clk)
        (!rst_n) |=> (pending_o == '0 && enable_o == '0 && !check_req));
endmodule

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic        wr_word = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] src_pulse = '0;
    logic        force_serial = 1'b0;
    logic        force_sound = 1'b0;
    logic [31:0] pending_o, enable_o;
    logic        irq, check_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_ctrl_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .wr_data(wr_data), .src_pulse(src_pulse),
        .force_serial(force_serial), .force_sound(force_sound),
        .pending_o(pending_o), .enable_o(enable_o), .irq(irq), .check_req(check_req)
    );

    // kind: 0 none, 1 pending (0x070), 2 enable (0x074), 3 other (0x078)
    typedef struct packed {
        logic [1:0]  kind;
        logic        word;
        logic [31:0] data;
        logic [31:0] src;
        logic        fser;
        logic        fsnd;
        logic [31:0] exp_pend;
        logic [31:0] exp_en;
        logic        exp_irq;
        logic        exp_chk;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R2 sources bits 3 and 9
        '{2'd0, 1'b1, 32'h0,          32'h0000_0208, 1'b0, 1'b0, 32'h0000_0208, 32'h0,          1'b0, 1'b0},
        // R6 enable bit 3 meets pending
        '{2'd2, 1'b1, 32'h0000_0008,  32'h0,         1'b0, 1'b0, 32'h0000_0208, 32'h0000_0008, 1'b1, 1'b1},
        // R4 all-ones ack drops disabled bit 9
        '{2'd1, 1'b1, 32'hFFFF_FFFF,  32'h0,         1'b0, 1'b0, 32'h0000_0008, 32'h0000_0008, 1'b1, 1'b0},
        // R3 zero in data acknowledges bit 3
        '{2'd1, 1'b1, 32'hFFFF_FFF7,  32'h0,         1'b0, 1'b0, 32'h0,         32'h0000_0008, 1'b0, 1'b0},
        // R9 half enable write, upper kept; source bit 16
        '{2'd2, 1'b0, 32'hABCD_FFFF,  32'h0001_0000, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_FFFF, 1'b0, 1'b0},
        // R10 write beside the registers ignored
        '{2'd3, 1'b1, 32'h0001_0000,  32'h0,         1'b0, 1'b0, 32'h0001_0000, 32'h0000_FFFF, 1'b0, 1'b0},
        // R5 forced serial removed by zero data; R9 upper pending kept
        '{2'd1, 1'b0, 32'hFFFF_0000,  32'h0,         1'b1, 1'b0, 32'h0001_0000, 32'h0000_FFFF, 1'b0, 1'b0},
        // R5 both forced, survive; R4 bit 16 disabled dropped; src bit 2
        '{2'd1, 1'b1, 32'hFFFF_FFFF,  32'h0000_0004, 1'b1, 1'b1, 32'h0000_0284, 32'h0000_FFFF, 1'b1, 1'b0},
        // R6 word enable write meets bit 2
        '{2'd2, 1'b1, 32'h0001_0004,  32'h0,         1'b0, 1'b0, 32'h0000_0284, 32'h0001_0004, 1'b1, 1'b1},
        // R8 source wins over clearing ack
        '{2'd1, 1'b1, 32'h0,          32'h0002_0004, 1'b0, 1'b0, 32'h0002_0004, 32'h0001_0004, 1'b1, 1'b0},
        // R9 half ack clears low, upper pending kept; R7 irq low
        '{2'd1, 1'b0, 32'h0000_0000,  32'h0,         1'b0, 1'b0, 32'h0002_0000, 32'h0001_0004, 1'b0, 1'b0},
        // R6 enable write with no overlap: no check pulse
        '{2'd2, 1'b0, 32'h0000_0000,  32'h0,         1'b0, 1'b0, 32'h0002_0000, 32'h0001_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_en        = (v.kind != 2'd0);
        wr_addr      = (v.kind == 2'd1) ? 12'h070 : (v.kind == 2'd2) ? 12'h074 : 12'h078;
        wr_word      = v.word;
        wr_data      = v.data;
        src_pulse    = v.src;
        force_serial = v.fser;
        force_sound  = v.fsnd;
        @(posedge clk);
        #1;
        wr_en = 1'b0; src_pulse = '0; force_serial = 1'b0; force_sound = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 pending", pending_o, 32'h0);
        chk("R1 enable", enable_o, 32'h0);
        chk("R1 irq/check", {30'h0, irq, check_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            chk($sformatf("vec%0d pending", i), pending_o, VECS[i].exp_pend);
            chk($sformatf("vec%0d enable", i), enable_o, VECS[i].exp_en);
            chk($sformatf("vec%0d R7 irq", i), {31'h0, irq}, {31'h0, VECS[i].exp_irq});
            chk($sformatf("vec%0d R6 check", i), {31'h0, check_req}, {31'h0, VECS[i].exp_chk});
        end

        // R6 check pulse lasts one cycle only
        apply('{2'd2, 1'b1, 32'h0002_0000, 32'h0, 1'b0, 1'b0, 32'h0002_0000, 32'h0002_0000, 1'b1, 1'b1});
        chk("R6 pulse high", {31'h0, check_req}, 32'h1);
        @(posedge clk); #1;
        chk("R6 pulse gone", {31'h0, check_req}, 32'h0);
        chk("R7 irq held", {31'h0, irq}, 32'h1);

        // R10 half write at 0x072 ignored
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h072; wr_word = 1'b0; wr_data = 32'h0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R10 pending at 0x072", pending_o, 32'h0002_0000);
        chk("R10 enable at 0x072", enable_o, 32'h0002_0000);

        // R2 DMA bit 3 held over idle cycles
        apply('{2'd0, 1'b1, 32'h0, 32'h0000_0008, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0});
        repeat (3) @(posedge clk);
        #1;
        chk("R2 held", pending_o, 32'h0002_0008);

        // R1 reset mid-run clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid pending", pending_o, 32'h0);
        chk("R1 mid enable", enable_o, 32'h0);
        chk("R1 mid irq", {31'h0, irq}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule